// File: doc/BRIEF.md
# Branch Condition and Jump Unit

This block resolves the control-flow instructions of a 64-bit packet-filter style virtual machine. A sequencer presents one instruction at a time: its opcode, the destination register value, the source register value, a 32-bit immediate, a 16-bit signed offset and the current program counter. The sequencer pulses `start` for one cycle. The unit then reports the program counter to fetch next, whether a branch was taken, and whether the program asked to terminate. The last three of these are qualified by a one-cycle `done` pulse.

Conditional jumps compare the destination value against either the sign-extended immediate or the source value. The unit supports equality, inequality, unsigned and two's-complement ordering, and a bit-test condition. A taken jump lands at PC+1+offset; any other outcome lands at PC+1. Branches and the unconditional jump always take two cycles. Program exit takes one cycle. A helper call hands the immediate, as a function number, to an external handler and completes only after that handler acknowledges it.

Top module: `jmp_unit`

## Requirements
- R1: Opcodes have low three bits 101, and bits 7:4 select the operation: 0 unconditional (0x05 only), 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit-test, 5 not-equal, 6 signed greater, 7 signed greater-or-equal, 8 call (0x85 only), 9 exit (0x95 only), A unsigned less, B unsigned less-or-equal, C signed less, D signed less-or-equal. The unconditional jump is always taken.
- R2: Equal, not-equal, and the four unsigned orderings compare the two 64-bit operands as unsigned numbers.
- R3: The four signed orderings compare the operands as two's-complement 64-bit numbers.
- R4: The bit-test branch is taken exactly when the bitwise AND of the operands is nonzero.
- R5: Opcode bit 3 set selects the source value as the second operand. Bit 3 clear selects the 32-bit immediate, sign-extended to 64 bits.
- R6: A taken jump reports next PC = PC + 1 + sign-extended offset. Any other completion reports PC + 1. Both wrap modulo 2^PC_W.
- R7: Jumps assert `done` on the second rising edge after the edge that samples `start`, taken or not.
- R8: Exit (0x95) asserts `done` with `is_exit`=1 and `taken`=0 on the edge after the one that samples `start`.
- R9: Call (0x85) raises `call_req` on the edge after `start`, with `call_id` = immediate. Both hold steady until `call_ack` is sampled high. `done` follows on the next edge, with `taken`=0. The minimum latency is therefore 2 cycles.
- R10: A `start` that arrives while an instruction is in progress is ignored and produces no completion.
- R11: Any other opcode completes like a jump (2 cycles), with `taken`=0, `is_exit`=0 and next PC = PC + 1.
- R12: Synchronous reset clears `done`, `taken`, `is_exit`, `call_req`, `call_id` and `next_pc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse presenting an instruction |
| opcode | input | 8 | Instruction opcode |
| dst | input | XLEN | Destination register value (first operand) |
| src | input | XLEN | Source register value |
| imm | input | IMM_W | Immediate; second operand or call function number |
| offset | input | OFF_W | Signed branch displacement |
| pc | input | PC_W | Program counter of the instruction |
| call_ack | input | 1 | Handler acknowledge of a call request |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken, valid with `done` |
| is_exit | output | 1 | Program exit, valid with `done` |
| next_pc | output | PC_W | Program counter to fetch next, valid with `done` |
| call_req | output | 1 | Call request to the external handler |
| call_id | output | IMM_W | Function number of the pending call |

## Verification
The bench builds the unit with 64-bit operands, a 32-bit immediate, a 16-bit offset and a 20-bit program counter. The narrow counter makes wrap-around in both directions reachable with small offsets from addresses near 0 and 0xFFFFF. The full 64-bit width keeps the all-ones value, which is the largest unsigned number and the smallest-magnitude negative number, available to separate the unsigned and signed orderings. The call handler's acknowledge delay is a bench variable, so the minimum 2-cycle call and longer waits are both reached.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

    localparam logic [7:0] OP_CALL = 8'h85;
    localparam logic [7:0] OP_EXIT = 8'h95;

    typedef enum logic [1:0] {
        K_BRANCH,
        K_EXIT,
        K_CALL,
        K_NONE
    } kind_e;

    typedef enum logic [3:0] {
        CND_ALWAYS,
        CND_EQ,
        CND_NE,
        CND_UGT,
        CND_UGE,
        CND_ULT,
        CND_ULE,
        CND_SGT,
        CND_SGE,
        CND_SLT,
        CND_SLE,
        CND_SET,
        CND_NEVER
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_CALL
    } state_e;

    typedef struct packed {
        kind_e kind;
        cond_e cond;
        logic  use_reg;
    } jdec_t;

    // Map an opcode onto operation kind, condition and operand source.
    function automatic jdec_t jdecode(input logic [7:0] op);
        jdec_t d;
        d.kind    = K_NONE;
        d.cond    = CND_NEVER;
        d.use_reg = op[3];
        if (op[2:0] == 3'b101) begin
            d.kind = K_BRANCH;
            unique case (op[7:4])
                4'h0: d.cond = op[3] ? CND_NEVER : CND_ALWAYS;
                4'h1: d.cond = CND_EQ;
                4'h2: d.cond = CND_UGT;
                4'h3: d.cond = CND_UGE;
                4'h4: d.cond = CND_SET;
                4'h5: d.cond = CND_NE;
                4'h6: d.cond = CND_SGT;
                4'h7: d.cond = CND_SGE;
                4'h8: if (!op[3]) d.kind = K_CALL;
                4'h9: if (!op[3]) d.kind = K_EXIT;
                4'hA: d.cond = CND_ULT;
                4'hB: d.cond = CND_ULE;
                4'hC: d.cond = CND_SLT;
                4'hD: d.cond = CND_SLE;
                default: d.cond = CND_NEVER;
            endcase
            if (op[0] && op[2] && (op[7:4] == 4'h0) && op[3]) d.kind = K_NONE;
            if ((op[7:4] == 4'h8 || op[7:4] == 4'h9) && op[3]) d.kind = K_NONE;
            if (op[7:4] == 4'hE || op[7:4] == 4'hF) d.kind = K_NONE;
        end
        return d;
    endfunction

endpackage

// File: rtl/jmp_operand_sel.sv
module jmp_operand_sel #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic             use_reg,
    input  logic [XLEN-1:0]  src,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  rhs
);
    localparam int PAD = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (PAD > 0) begin : g_sext
            assign imm_ext = {{PAD{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    assign rhs = use_reg ? src : imm_ext;
endmodule

// File: rtl/jmp_compare.sv
module jmp_compare
    import jmp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            hit
);
    logic eq, ult, slt, any_bit;

    // One shared set of comparators; the condition only selects among them.
    assign eq      = (lhs == rhs);
    assign ult     = (lhs < rhs);
    assign slt     = ($signed(lhs) < $signed(rhs));
    assign any_bit = |(lhs & rhs);

    always_comb begin
        unique case (cond)
            CND_ALWAYS: hit = 1'b1;
            CND_EQ:     hit = eq;
            CND_NE:     hit = !eq;
            CND_UGT:    hit = !ult && !eq;
            CND_UGE:    hit = !ult;
            CND_ULT:    hit = ult;
            CND_ULE:    hit = ult || eq;
            CND_SGT:    hit = !slt && !eq;
            CND_SGE:    hit = !slt;
            CND_SLT:    hit = slt;
            CND_SLE:    hit = slt || eq;
            CND_SET:    hit = any_bit;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/jmp_target.sv
module jmp_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             take,
    output logic [PC_W-1:0]  target
);
    localparam int PAD = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] seq_pc;

    generate
        if (PAD > 0) begin : g_sext
            assign off_ext = {{PAD{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[PC_W-1:0];
        end
    endgenerate

    assign seq_pc = pc + PC_W'(1);
    assign target = take ? (seq_pc + off_ext) : seq_pc;
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
    import jmp_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [XLEN-1:0]  dst,
    input  logic [XLEN-1:0]  src,
    input  logic [IMM_W-1:0] imm,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  pc,
    input  logic             call_ack,
    output logic             done,
    output logic             taken,
    output logic             is_exit,
    output logic [PC_W-1:0]  next_pc,
    output logic             call_req,
    output logic [IMM_W-1:0] call_id
);
    state_e          st_q;
    jdec_t           dec_in;
    cond_e           cond_q;
    logic [XLEN-1:0] rhs_in;
    logic [XLEN-1:0] lhs_q, rhs_q;
    logic [PC_W-1:0] pc_q;
    logic [OFF_W-1:0] off_q;
    logic            hit;
    logic [PC_W-1:0] tgt;
    logic            in_flight;

    logic             done_q, taken_q, exit_q, req_q;
    logic [PC_W-1:0]  npc_q;
    logic [IMM_W-1:0] id_q;

    assign dec_in    = jdecode(opcode);
    assign in_flight = (st_q != ST_IDLE);

    jmp_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
        .use_reg (dec_in.use_reg),
        .src     (src),
        .imm     (imm),
        .rhs     (rhs_in)
    );

    jmp_compare #(.XLEN(XLEN)) u_cmp (
        .cond (cond_q),
        .lhs  (lhs_q),
        .rhs  (rhs_q),
        .hit  (hit)
    );

    jmp_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc     (pc_q),
        .offset (off_q),
        .take   (hit && (st_q == ST_EVAL)),
        .target (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cond_q  <= CND_NEVER;
            lhs_q   <= '0;
            rhs_q   <= '0;
            pc_q    <= '0;
            off_q   <= '0;
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            exit_q  <= 1'b0;
            npc_q   <= '0;
            req_q   <= 1'b0;
            id_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q   <= pc;
                        off_q  <= offset;
                        lhs_q  <= dst;
                        rhs_q  <= rhs_in;
                        cond_q <= (dec_in.kind == K_BRANCH) ? dec_in.cond : CND_NEVER;
                        unique case (dec_in.kind)
                            K_EXIT: begin
                                done_q  <= 1'b1;
                                exit_q  <= 1'b1;
                                taken_q <= 1'b0;
                                npc_q   <= pc + PC_W'(1);
                            end
                            K_CALL: begin
                                req_q <= 1'b1;
                                id_q  <= imm;
                                st_q  <= ST_CALL;
                            end
                            default: st_q <= ST_EVAL;
                        endcase
                    end
                end
                ST_EVAL: begin
                    done_q  <= 1'b1;
                    exit_q  <= 1'b0;
                    taken_q <= hit;
                    npc_q   <= tgt;
                    st_q    <= ST_IDLE;
                end
                ST_CALL: begin
                    if (call_ack) begin
                        req_q   <= 1'b0;
                        done_q  <= 1'b1;
                        exit_q  <= 1'b0;
                        taken_q <= 1'b0;
                        npc_q   <= pc_q + PC_W'(1);
                        st_q    <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign taken    = taken_q;
    assign is_exit  = exit_q;
    assign next_pc  = npc_q;
    assign call_req = req_q;
    assign call_id  = id_q;
endmodule

// File: rtl/jmp_unit_chk.sv
module jmp_unit_chk #(
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [7:0]       opcode,
    input logic             busy,
    input logic             done,
    input logic             taken,
    input logic             is_exit,
    input logic             call_req,
    input logic             call_ack,
    input logic [IMM_W-1:0] call_id
);
    logic accept, acc_other, br_q, br_q2;

    assign accept    = start && !busy;
    assign acc_other = accept && (opcode != 8'h85) && (opcode != 8'h95);

    always_ff @(posedge clk) begin
        if (rst) begin
            br_q  <= 1'b0;
            br_q2 <= 1'b0;
        end else begin
            br_q  <= acc_other;
            br_q2 <= br_q;
        end
    end

    assert_branch_wait_R7: assert property (@(posedge clk) disable iff (rst)
        acc_other |=> (busy && !done));

    assert_branch_done_R7: assert property (@(posedge clk) disable iff (rst)
        br_q2 |-> done);

    assert_exit_fast_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && opcode == 8'h95) |=> (done && is_exit && !taken));

    assert_exit_untaken_R8: assert property (@(posedge clk) disable iff (rst)
        (done && is_exit) |-> !taken);

    assert_call_raise_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && opcode == 8'h85) |=> (call_req && !done));

    assert_call_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (call_req && !call_ack) |=> (call_req && $stable(call_id)));

    assert_call_finish_R9: assert property (@(posedge clk) disable iff (rst)
        (call_req && call_ack) |=> (done && !call_req && !taken));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (start && call_req && !call_ack) |=> !done);
endmodule

bind jmp_unit jmp_unit_chk #(.IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .busy     (in_flight),
    .done     (done),
    .taken    (taken),
    .is_exit  (is_exit),
    .call_req (call_req),
    .call_ack (call_ack),
    .call_id  (call_id)
);

// File: tb/test_jmp_unit.sv
`timescale 1ns/1ps
module test_jmp_unit;
    localparam int XLEN  = 64;
    localparam int IMM_W = 32;
    localparam int OFF_W = 16;
    localparam int PC_W  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [7:0]       opcode = '0;
    logic [XLEN-1:0]  dst = '0, src = '0;
    logic [IMM_W-1:0] imm = '0;
    logic [OFF_W-1:0] offset = '0;
    logic [PC_W-1:0]  pc = '0;
    logic             call_ack = 1'b0;
    logic             done, taken, is_exit, call_req;
    logic [PC_W-1:0]  next_pc;
    logic [IMM_W-1:0] call_id;

    always #2.5 clk = ~clk;

    jmp_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W), .PC_W(PC_W)) i_jmp_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .dst(dst), .src(src),
        .imm(imm), .offset(offset), .pc(pc), .call_ack(call_ack), .done(done),
        .taken(taken), .is_exit(is_exit), .next_pc(next_pc), .call_req(call_req),
        .call_id(call_id)
    );

    typedef struct {
        logic [PC_W-1:0] npc;
        bit              tk;
        bit              ex;
        int              lat;
        int              issue;
        string           req;
    } exp_t;

    exp_t q[$];
    int   compared = 0;
    int   mismatched = 0;
    int   cyc = 0;
    int   ack_delay = 0;
    logic [IMM_W-1:0] exp_id = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Independent model of the branch decision.
    function automatic bit model_taken(input logic [7:0] op, input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] s, input logic [IMM_W-1:0] im);
        logic [XLEN-1:0] b;
        b = op[3] ? s : {{(XLEN-IMM_W){im[IMM_W-1]}}, im};
        case (op)
            8'h05:        return 1'b1;
            8'h15, 8'h1d: return a == b;
            8'h55, 8'h5d: return a != b;
            8'h25, 8'h2d: return a > b;
            8'h35, 8'h3d: return a >= b;
            8'ha5, 8'had: return a < b;
            8'hb5, 8'hbd: return a <= b;
            8'h65, 8'h6d: return $signed(a) > $signed(b);
            8'h75, 8'h7d: return $signed(a) >= $signed(b);
            8'hc5, 8'hcd: return $signed(a) < $signed(b);
            8'hd5, 8'hdd: return $signed(a) <= $signed(b);
            8'h45, 8'h4d: return (a & b) != '0;
            default:      return 1'b0;
        endcase
    endfunction

    // Driver: presents one instruction, pushes its expectation, waits for it to retire.
    task automatic issue(input logic [7:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] s,
                         input logic [IMM_W-1:0] im, input logic [OFF_W-1:0] off,
                         input logic [PC_W-1:0] p, input string req, input bit wait_done);
        exp_t e;
        bit   tk;
        tk = (op == 8'h85 || op == 8'h95) ? 1'b0 : model_taken(op, a, s, im);
        e.tk    = tk;
        e.ex    = (op == 8'h95);
        e.npc   = tk ? (p + PC_W'(1) + {{(PC_W-OFF_W){off[OFF_W-1]}}, off}) : (p + PC_W'(1));
        e.lat   = (op == 8'h95) ? 1 : (op == 8'h85) ? 2 + ack_delay : 2;
        e.req   = req;
        @(negedge clk);
        opcode = op; dst = a; src = s; imm = im; offset = off; pc = p; start = 1'b1;
        if (op == 8'h85) exp_id = im;
        e.issue = cyc + 1;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (wait_done) while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compares each completion with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R10: unexpected done, actual=1 expected=0");
            end else begin
                exp_t e;
                int   lat;
                e = q.pop_front();
                lat = cyc - e.issue + 1;
                compared++;
                if (next_pc !== e.npc || taken !== e.tk || is_exit !== e.ex || lat != e.lat) begin
                    mismatched++;
                    $display("FAIL %s: actual npc=%h tk=%b ex=%b lat=%0d expected npc=%h tk=%b ex=%b lat=%0d",
                             e.req, next_pc, taken, is_exit, lat, e.npc, e.tk, e.ex, e.lat);
                end
            end
        end
    end

    // Call handler model (R9): checks the function number, then acknowledges after ack_delay.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && call_req && !call_ack) begin
                compared++;
                if (call_id !== exp_id) begin
                    mismatched++;
                    $display("FAIL R9: call_id actual=%h expected=%h", call_id, exp_id);
                end
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    if (call_req !== 1'b1 || call_id !== exp_id) begin
                        compared++; mismatched++;
                        $display("FAIL R9: request dropped, actual req=%b id=%h expected req=1 id=%h",
                                 call_req, call_id, exp_id);
                    end
                end
                call_ack = 1'b1;
                @(negedge clk);
                call_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
    end

    localparam logic [XLEN-1:0] ALL1 = '1;

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        compared++;
        if (done !== 1'b0 || taken !== 1'b0 || is_exit !== 1'b0 || call_req !== 1'b0 ||
            next_pc !== '0 || call_id !== '0) begin
            mismatched++;
            $display("FAIL R12: actual done=%b tk=%b ex=%b req=%b npc=%h id=%h expected all zero",
                     done, taken, is_exit, call_req, next_pc, call_id);
        end
        rst = 1'b0;

        issue(8'h05, 64'd0, 64'd0, 32'd0, -16'sd5, 20'h00100, "R1 ja", 1);
        issue(8'h15, 64'd7, 64'd0, 32'd7, 16'd10, 20'h00200, "R2 jeq imm", 1);
        issue(8'h1d, 64'd7, 64'd8, 32'd7, 16'd10, 20'h00200, "R2 jeq reg", 1);
        issue(8'h55, 64'd7, 64'd8, 32'd0, 16'd3, 20'h00300, "R2 jne", 1);
        issue(8'h25, ALL1, 64'd0, 32'd1, 16'd4, 20'h00400, "R2 jgt", 1);
        issue(8'h65, ALL1, 64'd0, 32'd1, 16'd4, 20'h00400, "R3 jsgt", 1);
        issue(8'had, 64'd5, ALL1, 32'd0, 16'd6, 20'h00500, "R2 jlt", 1);
        issue(8'hbd, 64'd9, 64'd9, 32'd0, 16'd6, 20'h00500, "R2 jle", 1);
        issue(8'h3d, 64'd9, 64'd10, 32'd0, 16'd6, 20'h00500, "R2 jge", 1);
        issue(8'hcd, ALL1, 64'd1, 32'd0, 16'd2, 20'h00600, "R3 jslt", 1);
        issue(8'h7d, 64'd1, ALL1, 32'd0, 16'd2, 20'h00600, "R3 jsge", 1);
        issue(8'hd5, 64'h8000_0000_0000_0000, 64'd0, 32'h8000_0000, 16'd2, 20'h00600, "R3 jsle", 1);
        issue(8'h45, 64'h0000_0000_0000_0f00, 64'd0, 32'h0000_0100, 16'd8, 20'h00700, "R4 jset hit", 1);
        issue(8'h4d, 64'h0000_0000_0000_00f0, 64'h0f, 32'd0, 16'd8, 20'h00700, "R4 jset miss", 1);
        issue(8'h15, ALL1, 64'd0, 32'hffff_ffff, 16'd1, 20'h00800, "R5 imm sext", 1);
        issue(8'h05, 64'd0, 64'd0, 32'd0, 16'd0, 20'hfffff, "R6 wrap up", 1);
        issue(8'h05, 64'd0, 64'd0, 32'd0, -16'sd2, 20'h00000, "R6 wrap down", 1);
        issue(8'h55, 64'd3, 64'd0, 32'd3, 16'd100, 20'hfffff, "R6 untaken wrap", 1);
        issue(8'h95, 64'd0, 64'd0, 32'd0, 16'd0, 20'h00900, "R8 exit", 1);
        issue(8'h95, 64'd0, 64'd0, 32'd0, 16'd0, 20'h00a00, "R8 exit again", 1);
        ack_delay = 0;
        issue(8'h85, 64'd0, 64'd0, 32'd17, 16'd9, 20'h00b00, "R9 call fast", 1);
        ack_delay = 3;
        issue(8'h85, 64'd0, 64'd0, 32'hdead_0001, 16'd9, 20'h00c00, "R9 call slow", 1);
        // R10: a second start during a pending call is dropped.
        ack_delay = 5;
        issue(8'h85, 64'd0, 64'd0, 32'd42, 16'd0, 20'h00d00, "R10 call", 0);
        @(negedge clk);
        opcode = 8'h95; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        for (int k = 0; k < 4; k++) @(negedge clk);
        compared++;
        if (done !== 1'b0 || q.size() != 0) begin
            mismatched++;
            $display("FAIL R10: actual done=%b expected 0", done);
        end
        ack_delay = 0;
        issue(8'h0d, 64'd0, 64'd0, 32'd0, 16'd20, 20'h00e00, "R11 unknown 0x0d", 1);
        issue(8'he5, 64'd0, 64'd0, 32'd0, 16'd20, 20'h00e00, "R11 unknown 0xe5", 1);
        issue(8'h8d, 64'd0, 64'd0, 32'd0, 16'd20, 20'h00e00, "R11 unknown 0x8d", 1);
        issue(8'h07, 64'd0, 64'd0, 32'd0, 16'd20, 20'h00e00, "R11 non-jump", 1);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule